// File: doc/BRIEF.md
# Dual-Mode Cycle Counter With Snapshot

This block keeps a wide running count of processor clock cycles since reset. The count has two modes, selected by a mode input. In one mode it advances on every clock. In the other it advances only on cycles where the core is not stalled, so stall time is left out of the measurement.

Software reads the count through 32-bit ports. A free-running master counter carries the live value. A snapshot register copies the master only when an interruptible jump completes without being interrupted. Between two such jumps, the low and high halves of the snapshot come from the same instant, so two narrow reads give one coherent wide value. A third port exposes the low half of the live master, for cycle-exact timing of short code stretches.

The mode input is registered before it is used. Reset forces the registered mode to "count every cycle".

Top module: `cycle_tally`

## Requirements
- R1: While `rst` is high at a clock edge, the master count and the snapshot clear to zero and the registered mode becomes 1 (count every cycle).
- R2: `mode_in` is captured into the registered mode on each edge. The count decision at an edge uses the mode captured at the previous edge, so a change on `mode_in` takes effect one cycle later.
- R3: With registered mode 1, the master count rises by one on every edge, whatever the value of `stall`.
- R4: With registered mode 0, the master count rises by one on an edge where `stall` is low, and holds on an edge where `stall` is high.
- R5: On an edge with `jump_ok` high, the snapshot takes the master value from before that edge's increment.
- R6: On an edge with `jump_ok` low, the snapshot keeps its value.
- R7: `snap_lo` carries snapshot bits [RD_W-1:0] and `snap_hi` carries bits [CNT_W-1:RD_W]. `live_lo` carries master bits [RD_W-1:0]. All three are registers, with no combinational path from the inputs.
- R8: The master count wraps modulo 2^CNT_W to zero without saturating. A carry out of the low half shows up in the high half at the next snapshot.
- R9: A stall held during a jump in mode 0 does not block the capture. The snapshot still loads, and the master holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| stall | input | 1 | High on a cycle in which the core is stalled |
| mode_in | input | 1 | 1 = count all cycles, 0 = count non-stall cycles only |
| jump_ok | input | 1 | Strobe for an interruptible jump that completed without an exception |
| snap_lo | output | RD_W | Low half of the snapshot |
| snap_hi | output | RD_W | High half of the snapshot |
| live_lo | output | RD_W | Low half of the live master count |

## Verification
The bench targets four corner cases:
- A jump and an increment on the same edge. A design that captured after the increment would show a snapshot one count too high.
- A mode change on `mode_in`. A design that used the mode without registering it would count, or skip, a stall cycle one edge early.
- A jump during a stall in mode 0. A design that gated capture with the count enable would miss the load.
- A narrow instance driven past the carry into its high half and through full wraparound. A design that saturated, or dropped the carry, would freeze or lose the upper half.

// File: rtl/cyc_pkg.sv
package cyc_pkg;
  typedef enum logic {
    CNT_NONSTALL = 1'b0,
    CNT_ALL      = 1'b1
  } cnt_mode_e;
endpackage

// File: rtl/cyc_master.sv
module cyc_master
  import cyc_pkg::*;
#(
  parameter int CNT_W = 64
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             stall,
  input  logic             mode_in,
  output logic [CNT_W-1:0] master_q
);
  cnt_mode_e mode_q;
  logic      step;

  // R2: mode is registered, reset value counts every cycle
  always_ff @(posedge clk) begin
    if (rst) mode_q <= CNT_ALL;
    else     mode_q <= cnt_mode_e'(mode_in);
  end

  assign step = (mode_q == CNT_ALL) || !stall;

  always_ff @(posedge clk) begin
    if (rst)       master_q <= '0;
    else if (step) master_q <= master_q + 1'b1;
  end

  AST_RST_CLEAR: assert property (@(posedge clk) rst |=> (master_q == '0 && mode_q == CNT_ALL)); // R1
  AST_MODE_FOLLOW: assert property (@(posedge clk) disable iff (rst) !$past(rst) |-> (mode_q == cnt_mode_e'($past(mode_in)))); // R2
  AST_ALL_STEP: assert property (@(posedge clk) disable iff (rst) (mode_q == CNT_ALL) |=> master_q == $past(master_q) + 1'b1); // R3
  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (rst) (mode_q == CNT_NONSTALL && stall) |=> $stable(master_q)); // R4
  AST_FREE_STEP: assert property (@(posedge clk) disable iff (rst) (mode_q == CNT_NONSTALL && !stall) |=> master_q == $past(master_q) + 1'b1); // R4
endmodule

// File: rtl/cyc_snap.sv
module cyc_snap #(
  parameter int CNT_W = 64
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             jump_ok,
  input  logic [CNT_W-1:0] master_q,
  output logic [CNT_W-1:0] snap_q
);
  // captures the pre-increment master value
  always_ff @(posedge clk) begin
    if (rst)          snap_q <= '0;
    else if (jump_ok) snap_q <= master_q;
  end

  AST_SNAP_LOAD: assert property (@(posedge clk) disable iff (rst) jump_ok |=> snap_q == $past(master_q)); // R5
  AST_SNAP_KEEP: assert property (@(posedge clk) disable iff (rst) !jump_ok |=> $stable(snap_q)); // R6
  AST_SNAP_RST: assert property (@(posedge clk) rst |=> snap_q == '0); // R1
endmodule

// File: rtl/cyc_ports.sv
module cyc_ports #(
  parameter int CNT_W = 64,
  parameter int RD_W  = 32
) (
  input  logic [CNT_W-1:0] master_q,
  input  logic [CNT_W-1:0] snap_q,
  output logic [RD_W-1:0]  snap_lo,
  output logic [RD_W-1:0]  snap_hi,
  output logic [RD_W-1:0]  live_lo
);
  localparam int HI_W = CNT_W - RD_W;

  assign snap_lo = snap_q[RD_W-1:0];
  assign live_lo = master_q[RD_W-1:0];

  generate
    if (HI_W >= RD_W) begin : g_full
      assign snap_hi = snap_q[RD_W+RD_W-1:RD_W];
    end else begin : g_pad
      assign snap_hi = {{(RD_W-HI_W){1'b0}}, snap_q[CNT_W-1:RD_W]};
    end
  endgenerate
endmodule

// File: rtl/cycle_tally.sv
module cycle_tally #(
  parameter int CNT_W = 64,
  parameter int RD_W  = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            stall,
  input  logic            mode_in,
  input  logic            jump_ok,
  output logic [RD_W-1:0] snap_lo,
  output logic [RD_W-1:0] snap_hi,
  output logic [RD_W-1:0] live_lo
);
  logic [CNT_W-1:0] master_q;
  logic [CNT_W-1:0] snap_q;

  cyc_master #(.CNT_W(CNT_W)) u_master (
    .clk(clk), .rst(rst), .stall(stall), .mode_in(mode_in), .master_q(master_q)
  );

  cyc_snap #(.CNT_W(CNT_W)) u_snap (
    .clk(clk), .rst(rst), .jump_ok(jump_ok), .master_q(master_q), .snap_q(snap_q)
  );

  cyc_ports #(.CNT_W(CNT_W), .RD_W(RD_W)) u_ports (
    .master_q(master_q), .snap_q(snap_q),
    .snap_lo(snap_lo), .snap_hi(snap_hi), .live_lo(live_lo)
  );

  AST_WRAP: assert property (@(posedge clk) disable iff (rst) ($past(master_q) == {CNT_W{1'b1}} && master_q != $past(master_q)) |-> master_q == '0); // R8
endmodule

// File: tb/sim_cycle_tally.sv
module sim_cycle_tally;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic stall = 1'b0;
  logic mode_in = 1'b1;
  logic jump_ok = 1'b0;

  logic [31:0] w_slo, w_shi, w_llo;
  logic [7:0]  n_slo, n_shi, n_llo;

  always #2 clk = ~clk;

  cycle_tally u0 (
    .clk(clk), .rst(rst), .stall(stall), .mode_in(mode_in), .jump_ok(jump_ok),
    .snap_lo(w_slo), .snap_hi(w_shi), .live_lo(w_llo)
  );

  cycle_tally #(.CNT_W(16), .RD_W(8)) u1 (
    .clk(clk), .rst(rst), .stall(stall), .mode_in(mode_in), .jump_ok(jump_ok),
    .snap_lo(n_slo), .snap_hi(n_shi), .live_lo(n_llo)
  );

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  int cycles = 0;

  // behavioural model
  logic [63:0] m_w, s_w;
  logic [15:0] m_n, s_n;
  bit mode_m;
  bit last_jump, last_mode;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(input bit st, input bit md, input bit jp);
    stall = st; mode_in = md; jump_ok = jp;
    @(posedge clk);
    cycles++;
    last_mode = mode_m;
    last_jump = jp;
    if (rst) begin
      m_w = 0; s_w = 0; m_n = 0; s_n = 0; mode_m = 1'b1;
    end else begin
      if (jp) begin s_w = m_w; s_n = m_n; end
      if (mode_m || !st) begin m_w = m_w + 64'd1; m_n = m_n + 16'd1; end
      mode_m = md;
    end
    @(negedge clk);
    if (!rst) begin
      chk(last_mode ? "R3 live count" : "R4 live count", {32'd0, w_llo}, {32'd0, m_w[31:0]});
      chk(last_jump ? "R5 snapshot" : "R6 snapshot", {w_shi, w_slo}, s_w);
      chk("R7 narrow ports", {40'd0, n_shi, n_slo, n_llo}, {40'd0, s_n, m_n[7:0]});
    end
  endtask

  initial begin : watchdog
    while (!done) begin
      @(posedge clk);
      if (cycles > 180000 && !done) begin
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    m_w = 0; s_w = 0; m_n = 0; s_n = 0; mode_m = 1'b1;
    rst = 1'b1;
    step(1'b1, 1'b0, 1'b1);
    step(1'b1, 1'b0, 1'b1);
    chk("R1 reset snap", {w_shi, w_slo}, 64'd0);
    chk("R1 reset live", {32'd0, w_llo}, 64'd0);
    rst = 1'b0;
    // R1: reset leaves mode at 1, so a stall in the first cycle still counts
    step(1'b1, 1'b1, 1'b0);
    chk("R1 mode reset to count-all", {32'd0, w_llo}, 64'd1);
    // R3: stalls counted in mode 1
    for (int i = 0; i < 20; i++) step(i[0], 1'b1, 1'b0);
    chk("R3 all cycles", {32'd0, w_llo}, 64'd21);
    // R2: mode drops to 0 together with a stall: this edge still counts
    step(1'b1, 1'b0, 1'b0);
    chk("R2 mode latency", {32'd0, w_llo}, 64'd22);
    step(1'b1, 1'b0, 1'b0);
    chk("R4 stall held", {32'd0, w_llo}, 64'd22);
    // R9: jump during a stall in mode 0
    step(1'b1, 1'b0, 1'b1);
    chk("R9 jump in stall snap", {w_shi, w_slo}, 64'd22);
    chk("R9 jump in stall live", {32'd0, w_llo}, 64'd22);
    // R5: jump with an increment on the same edge
    step(1'b0, 1'b0, 1'b1);
    chk("R5 pre-increment capture", {w_shi, w_slo}, 64'd22);
    chk("R5 live after", {32'd0, w_llo}, 64'd23);
    // R2: back to mode 1 with a stall: this edge holds
    step(1'b1, 1'b1, 1'b0);
    chk("R2 mode latency back", {32'd0, w_llo}, 64'd23);
    // mixed traffic
    for (int i = 0; i < 3000; i++)
      step(($urandom % 3) == 0, ($urandom % 4) != 0, ($urandom % 7) == 0);
    // R8: run the narrow instance through its high half and its wrap
    for (int i = 0; i < 70000; i++) step(1'b0, 1'b1, (i % 257) == 0);
    step(1'b0, 1'b1, 1'b1);
    step(1'b0, 1'b1, 1'b0);
    chk("R8 narrow snap after wrap", {48'd0, n_shi, n_slo}, {48'd0, s_n});
    chk("R8 wide live", {32'd0, w_llo}, {32'd0, m_w[31:0]});
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule